// File: doc/BRIEF.md
# Pixel Capture Front End

This block is the first register stage of a display link transmitter. Each clock it samples a parallel pixel bus, two pixels of PIX_W bits each plus the enable and the two sync lines. The clock edge on which the bus is sampled and the level that marks active data are both chosen by static configuration inputs. The outputs are a registered, cleaned-up view of the bus for the serializer lanes that follow: the pixel words, an enable that is always active-high, the syncs, the decoded link mode and the enables for the lanes and the extra clock.

A two-bit mode code selects one of three ways of running the links: one pixel per clock on one link, one pixel per clock spread over two links, or two pixels per clock on two links. The upper pixel word is used only in the two-pixel mode. The second link and the extra output clock are switched off in the one-link mode. A power-up input turns every lane enable off and clears the captured data. All configuration inputs pass through a register, so a change takes effect at a known clock edge.

Top module: `pix_capture_front`

## Requirements
- R1: While reset is held, and until the first capture after it, every output is zero: pixel words, enable, syncs, mode code and all lane enables.
- R2: With `cfg_rise_edge` high, the bus value present at a rising clock edge appears on the outputs right after that same edge.
- R3: With `cfg_rise_edge` low, the bus value present at a falling clock edge appears on the outputs right after the next rising edge, and the value present at that rising edge is not used.
- R4: `de_act_q` is high for active data in both polarities: it follows `de_in` when `cfg_de_high` is 1 and is its inverse when `cfg_de_high` is 0.
- R5: `link_mode_q` reports the decoded mode: code 2'b00 is one pixel on one link, 2'b01 is one pixel on two links, 2'b10 is two pixels on two links, and the unused code 2'b11 is treated as 2'b00.
- R6: `pix_hi_q` carries the captured upper pixel only in mode 2'b10. In the other modes it is held at zero whatever `pix_hi_in` carries.
- R7: While powered, `link0_en` is 1 in every mode. `link1_en` and `aux_clk_en` are 1 in modes 2'b01 and 2'b10 and 0 in mode 2'b00.
- R8: While `pwr_up` is low, all three lane enables are 0 and the pixel words, enable and syncs are zero. Normal capture and enables return once `pwr_up` is high again.
- R9: A configuration input changed before rising edge k is registered at edge k. It governs the outputs written at edge k+1 and later, and the outputs written at edge k still follow the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_up | input | 1 | 1 = operating, 0 = lanes disabled and data cleared |
| cfg_rise_edge | input | 1 | 1 = sample on the rising edge, 0 = sample on the falling edge |
| cfg_de_high | input | 1 | 1 = active data when `de_in` is high, 0 = when low |
| cfg_link_mode | input | 2 | Link mode code (see R5) |
| pix_lo_in | input | PIX_W | First (lower) pixel word |
| pix_hi_in | input | PIX_W | Second (upper) pixel word |
| de_in | input | 1 | Data enable, polarity set by `cfg_de_high` |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| pix_lo_q | output | PIX_W | Captured lower pixel |
| pix_hi_q | output | PIX_W | Captured upper pixel, zero outside mode 2'b10 |
| de_act_q | output | 1 | Captured enable, active-high |
| hsync_q | output | 1 | Captured horizontal sync |
| vsync_q | output | 1 | Captured vertical sync |
| link_mode_q | output | 2 | Decoded mode code |
| link0_en | output | 1 | Enable for the first link and its clock |
| link1_en | output | 1 | Enable for the second link's data lanes |
| aux_clk_en | output | 1 | Enable for the second output clock |

## Verification
The bench drives a different bus value in each half of a clock period: one value just after the rising edge and another just after the falling edge. The captured word therefore shows which edge did the sampling. Each mode code is tried with a non-zero upper word, so a missing gate on the upper pixel or a wrong lane enable shows up directly. Both enable polarities are tried with the enable input high and low, which separates an inversion error from a stuck output. A configuration flip between two edges, and a power-down pulse, pin the edge at which each change first takes effect.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;

  typedef enum logic [1:0] {
    LM_ONE_LINK = 2'b00,
    LM_SPLIT    = 2'b01,
    LM_WIDE     = 2'b10
  } link_mode_e;

  typedef struct packed {
    logic       pwr;
    logic       rise;
    logic       de_hi;
    link_mode_e mode;
  } cfg_t;

  // Unused code 2'b11 falls back to the lowest-power mode.
  function automatic link_mode_e decode_mode(input logic [1:0] code);
    link_mode_e m;
    case (code)
      2'b01:   m = LM_SPLIT;
      2'b10:   m = LM_WIDE;
      default: m = LM_ONE_LINK;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pixcap_rst_sync.sv
module pixcap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pixcap_cfg_reg.sv
module pixcap_cfg_reg
  import pixcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_up,
  input  logic       cfg_rise_edge,
  input  logic       cfg_de_high,
  input  logic [1:0] cfg_link_mode,
  output cfg_t       cfg_q
);
  cfg_t cfg_d;

  always_comb begin
    cfg_d.pwr   = pwr_up;
    cfg_d.rise  = cfg_rise_edge;
    cfg_d.de_hi = cfg_de_high;
    cfg_d.mode  = decode_mode(cfg_link_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '{pwr: 1'b0, rise: 1'b1, de_hi: 1'b1, mode: LM_ONE_LINK};
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/pixcap_fall_stage.sv
module pixcap_fall_stage #(
  parameter int BUS_W = 51
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_q
);
  logic [BUS_W-1:0] bus_d;

  always_comb begin
    bus_d = en ? bus_in : bus_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) bus_q <= '0;
    else        bus_q <= bus_d;
  end
endmodule

// File: rtl/pixcap_out_stage.sv
module pixcap_out_stage
  import pixcap_pkg::*;
#(
  parameter int PIX_W = 24,
  localparam int BUS_W = 2 * PIX_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg_q,
  input  logic [BUS_W-1:0] rise_bus,
  input  logic [BUS_W-1:0] fall_bus,
  output logic [PIX_W-1:0] pix_lo_q,
  output logic [PIX_W-1:0] pix_hi_q,
  output logic             de_act_q,
  output logic             hsync_q,
  output logic             vsync_q,
  output logic [1:0]       link_mode_q,
  output logic             link0_en,
  output logic             link1_en,
  output logic             aux_clk_en
);
  logic [BUS_W-1:0] sel_bus;
  logic [PIX_W-1:0] lo_d, hi_d;
  logic             de_d, hs_d, vs_d, l0_d, l1_d, ck_d;
  logic             wide, two_links;

  always_comb begin
    sel_bus   = cfg_q.rise ? rise_bus : fall_bus;
    wide      = (cfg_q.mode == LM_WIDE);
    two_links = (cfg_q.mode != LM_ONE_LINK);
    lo_d = '0;
    hi_d = '0;
    de_d = 1'b0;
    hs_d = 1'b0;
    vs_d = 1'b0;
    l0_d = 1'b0;
    l1_d = 1'b0;
    ck_d = 1'b0;
    if (cfg_q.pwr) begin
      lo_d = sel_bus[PIX_W+2:3];
      hi_d = wide ? sel_bus[BUS_W-1:PIX_W+3] : '0;
      de_d = cfg_q.de_hi ? sel_bus[0] : ~sel_bus[0];
      hs_d = sel_bus[1];
      vs_d = sel_bus[2];
      l0_d = 1'b1;
      l1_d = two_links;
      ck_d = two_links;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_lo_q    <= '0;
      pix_hi_q    <= '0;
      de_act_q    <= 1'b0;
      hsync_q     <= 1'b0;
      vsync_q     <= 1'b0;
      link_mode_q <= 2'b00;
      link0_en    <= 1'b0;
      link1_en    <= 1'b0;
      aux_clk_en  <= 1'b0;
    end else begin
      pix_lo_q    <= lo_d;
      pix_hi_q    <= hi_d;
      de_act_q    <= de_d;
      hsync_q     <= hs_d;
      vsync_q     <= vs_d;
      link_mode_q <= cfg_q.mode;
      link0_en    <= l0_d;
      link1_en    <= l1_d;
      aux_clk_en  <= ck_d;
    end
  end
endmodule

// File: rtl/pix_capture_front.sv
module pix_capture_front
  import pixcap_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_up,
  input  logic             cfg_rise_edge,
  input  logic             cfg_de_high,
  input  logic [1:0]       cfg_link_mode,
  input  logic [PIX_W-1:0] pix_lo_in,
  input  logic [PIX_W-1:0] pix_hi_in,
  input  logic             de_in,
  input  logic             hsync_in,
  input  logic             vsync_in,
  output logic [PIX_W-1:0] pix_lo_q,
  output logic [PIX_W-1:0] pix_hi_q,
  output logic             de_act_q,
  output logic             hsync_q,
  output logic             vsync_q,
  output logic [1:0]       link_mode_q,
  output logic             link0_en,
  output logic             link1_en,
  output logic             aux_clk_en
);
  localparam int BUS_W = 2 * PIX_W + 3;

  logic             rst_sync_n;
  cfg_t             cfg_q;
  logic [BUS_W-1:0] in_bus;
  logic [BUS_W-1:0] fall_bus;

  assign in_bus = {pix_hi_in, pix_lo_in, vsync_in, hsync_in, de_in};

  pixcap_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pixcap_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .pwr_up(pwr_up),
    .cfg_rise_edge(cfg_rise_edge), .cfg_de_high(cfg_de_high),
    .cfg_link_mode(cfg_link_mode), .cfg_q(cfg_q)
  );

  pixcap_fall_stage #(.BUS_W(BUS_W)) u_fall (
    .clk(clk), .rst_n(rst_sync_n), .en(cfg_q.pwr),
    .bus_in(in_bus), .bus_q(fall_bus)
  );

  pixcap_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .cfg_q(cfg_q),
    .rise_bus(in_bus), .fall_bus(fall_bus),
    .pix_lo_q(pix_lo_q), .pix_hi_q(pix_hi_q), .de_act_q(de_act_q),
    .hsync_q(hsync_q), .vsync_q(vsync_q), .link_mode_q(link_mode_q),
    .link0_en(link0_en), .link1_en(link1_en), .aux_clk_en(aux_clk_en)
  );
endmodule

// File: rtl/pixcap_chk.sv
module pixcap_chk #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             srst_n,
  input logic             pwr_up,
  input logic             cfg_rise_edge,
  input logic             cfg_de_high,
  input logic [1:0]       cfg_link_mode,
  input logic [PIX_W-1:0] pix_lo_in,
  input logic             de_in,
  input logic [PIX_W-1:0] pix_lo_q,
  input logic [PIX_W-1:0] pix_hi_q,
  input logic             de_act_q,
  input logic [1:0]       link_mode_q,
  input logic             link0_en,
  input logic             link1_en,
  input logic             aux_clk_en
);
  logic [1:0] warm_cnt;
  logic       ready;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)               warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign ready = (warm_cnt == 2'd3);

  // R2: rising-edge capture passes the bus sampled one edge earlier
  a_r2_rise_capture: assert property (@(posedge clk) disable iff (!srst_n)
    ready && $past(cfg_rise_edge, 2) && $past(pwr_up, 2) |-> pix_lo_q == $past(pix_lo_in));

  // R4: active-high normalisation of the enable, both polarities
  a_r4_de_active_high: assert property (@(posedge clk) disable iff (!srst_n)
    ready && $past(cfg_rise_edge, 2) && $past(pwr_up, 2) && $past(cfg_de_high, 2)
    |-> de_act_q == $past(de_in));
  a_r4_de_active_low: assert property (@(posedge clk) disable iff (!srst_n)
    ready && $past(cfg_rise_edge, 2) && $past(pwr_up, 2) && !$past(cfg_de_high, 2)
    |-> de_act_q == !$past(de_in));

  // R5: decoded mode follows the code registered two edges earlier
  a_r5_mode_decode: assert property (@(posedge clk) disable iff (!srst_n)
    ready |-> link_mode_q == (($past(cfg_link_mode, 2) == 2'b11) ? 2'b00 : $past(cfg_link_mode, 2)));

  // R6: upper pixel zero outside the two-pixel mode
  a_r6_hi_zero: assert property (@(posedge clk) disable iff (!srst_n)
    ready && $past(cfg_link_mode, 2) != 2'b10 |-> pix_hi_q == '0);

  // R7: one-link mode keeps the second link and clock off
  a_r7_one_link_enables: assert property (@(posedge clk) disable iff (!srst_n)
    ready && $past(pwr_up, 2) && ($past(cfg_link_mode, 2) == 2'b00 || $past(cfg_link_mode, 2) == 2'b11)
    |-> link0_en && !link1_en && !aux_clk_en);

  // R8: powered down means no lane enabled and no active data
  a_r8_power_down: assert property (@(posedge clk) disable iff (!srst_n)
    ready && !$past(pwr_up, 2) |-> !link0_en && !link1_en && !aux_clk_en && !de_act_q);
endmodule

bind pix_capture_front pixcap_chk #(.PIX_W(PIX_W)) u_pixcap_chk (
  .clk(clk), .srst_n(rst_sync_n), .pwr_up(pwr_up),
  .cfg_rise_edge(cfg_rise_edge), .cfg_de_high(cfg_de_high),
  .cfg_link_mode(cfg_link_mode), .pix_lo_in(pix_lo_in), .de_in(de_in),
  .pix_lo_q(pix_lo_q), .pix_hi_q(pix_hi_q), .de_act_q(de_act_q),
  .link_mode_q(link_mode_q), .link0_en(link0_en), .link1_en(link1_en),
  .aux_clk_en(aux_clk_en)
);

// File: tb/pix_capture_front_bench.sv
module pix_capture_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pwr_up, cfg_rise_edge, cfg_de_high;
  logic [1:0]    cfg_link_mode;
  logic [PW-1:0] pix_lo_in, pix_hi_in;
  logic          de_in, hsync_in, vsync_in;
  logic [PW-1:0] pix_lo_q, pix_hi_q;
  logic          de_act_q, hsync_q, vsync_q;
  logic [1:0]    link_mode_q;
  logic          link0_en, link1_en, aux_clk_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_capture_front #(.PIX_W(PW)) u_pix_capture_front (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up),
    .cfg_rise_edge(cfg_rise_edge), .cfg_de_high(cfg_de_high),
    .cfg_link_mode(cfg_link_mode), .pix_lo_in(pix_lo_in), .pix_hi_in(pix_hi_in),
    .de_in(de_in), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .pix_lo_q(pix_lo_q), .pix_hi_q(pix_hi_q), .de_act_q(de_act_q),
    .hsync_q(hsync_q), .vsync_q(vsync_q), .link_mode_q(link_mode_q),
    .link0_en(link0_en), .link1_en(link1_en), .aux_clk_en(aux_clk_en)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [PW-1:0] lo, input logic [PW-1:0] hi,
                       input logic de, input logic hs, input logic vs);
    pix_lo_in = lo; pix_hi_in = hi; de_in = de; hsync_in = hs; vsync_in = vs;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
  endtask

  // Drives F after a rising edge, R after the falling edge, samples after the next rising edge.
  task automatic two_phase(input logic [PW-1:0] f_lo, input logic [PW-1:0] f_hi, input logic f_de,
                           input logic [PW-1:0] r_lo, input logic [PW-1:0] r_hi, input logic r_de);
    @(posedge clk); #2;
    drive(f_lo, f_hi, f_de, 1'b1, 1'b0);
    @(negedge clk); #2;
    drive(r_lo, r_hi, r_de, 1'b0, 1'b1);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    pwr_up = 1'b1; cfg_rise_edge = 1'b1; cfg_de_high = 1'b1; cfg_link_mode = 2'b10;
    drive(24'hABCDEF, 24'h123456, 1'b1, 1'b1, 1'b1);
    repeat (3) @(posedge clk);
    #1;
    check("R1 lo", pix_lo_q, 0);
    check("R1 hi", pix_hi_q, 0);
    check("R1 ctl", {de_act_q, hsync_q, vsync_q, link_mode_q}, 0);
    check("R1 en", {link0_en, link1_en, aux_clk_en}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_rise();
    cfg_rise_edge = 1'b1; cfg_de_high = 1'b1; cfg_link_mode = 2'b10; settle();
    two_phase(24'h111111, 24'h222222, 1'b0, 24'h333333, 24'h444444, 1'b1);
    check("R2 lo", pix_lo_q, 24'h333333);
    check("R2 hi", pix_hi_q, 24'h444444);
    check("R2 sync", {hsync_q, vsync_q}, 2'b01);
    check("R4 de high", de_act_q, 1'b1);
  endtask

  task automatic t_fall();
    cfg_rise_edge = 1'b0; settle();
    two_phase(24'h5A5A5A, 24'h0F0F0F, 1'b1, 24'hA5A5A5, 24'hF0F0F0, 1'b0);
    check("R3 lo", pix_lo_q, 24'h5A5A5A);
    check("R3 hi", pix_hi_q, 24'h0F0F0F);
    check("R3 sync", {hsync_q, vsync_q}, 2'b10);
  endtask

  task automatic t_polarity();
    cfg_rise_edge = 1'b1; cfg_de_high = 1'b0; settle();
    two_phase(24'h0, 24'h0, 1'b1, 24'h000001, 24'h0, 1'b0);
    check("R4 low-active de=0", de_act_q, 1'b1);
    two_phase(24'h0, 24'h0, 1'b0, 24'h000002, 24'h0, 1'b1);
    check("R4 low-active de=1", de_act_q, 1'b0);
    cfg_de_high = 1'b1; settle();
    two_phase(24'h0, 24'h0, 1'b1, 24'h000003, 24'h0, 1'b0);
    check("R4 high-active de=0", de_act_q, 1'b0);
  endtask

  task automatic t_modes();
    cfg_rise_edge = 1'b1;
    for (int c = 0; c < 4; c++) begin
      logic [1:0] exp_mode;
      logic       wide, dual;
      cfg_link_mode = c[1:0];
      exp_mode = (c == 3) ? 2'b00 : c[1:0];
      wide = (c == 2);
      dual = (c == 1) || (c == 2);
      settle();
      two_phase(24'h0, 24'h0, 1'b0, 24'h00C0DE + 24'(c), 24'hFEED00 + 24'(c), 1'b1);
      check("R5 mode", link_mode_q, exp_mode);
      check("R6 hi gate", pix_hi_q, wide ? 24'hFEED00 + 24'(c) : 24'h0);
      check("R6 lo pass", pix_lo_q, 24'h00C0DE + 24'(c));
      check("R7 enables", {link0_en, link1_en, aux_clk_en}, {1'b1, dual, dual});
    end
  endtask

  task automatic t_power();
    cfg_link_mode = 2'b10; cfg_rise_edge = 1'b1; settle();
    @(posedge clk); #2;
    pwr_up = 1'b0;
    drive(24'h777777, 24'h888888, 1'b1, 1'b1, 1'b1);
    @(posedge clk); #1;
    check("R8 one edge later still on", link0_en, 1'b1);
    @(posedge clk); #1;
    check("R8 enables off", {link0_en, link1_en, aux_clk_en}, 0);
    check("R8 data cleared", {pix_lo_q, pix_hi_q}, 0);
    check("R8 ctl cleared", {de_act_q, hsync_q, vsync_q}, 0);
    pwr_up = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R8 resume enables", {link0_en, link1_en, aux_clk_en}, 3'b111);
    check("R8 resume data", pix_lo_q, 24'h777777);
  endtask

  task automatic t_cfg_timing();
    cfg_rise_edge = 1'b1; cfg_link_mode = 2'b10; settle();
    @(posedge clk); #2;
    cfg_rise_edge = 1'b0;
    drive(24'h0A0A0A, 24'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); #2;
    drive(24'h0B0B0B, 24'h0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R9 old edge at first boundary", pix_lo_q, 24'h0B0B0B);
    #1; drive(24'h0C0C0C, 24'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); #2;
    drive(24'h0D0D0D, 24'h0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R9 new edge one later", pix_lo_q, 24'h0C0C0C);
    cfg_rise_edge = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_polarity();
    t_modes();
    t_power();
    t_cfg_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule